// File: doc/BRIEF.md
# Packet CRC-32 Tail Insertion and Checking

This block sits in the error-detection path of a network interface. It carries two CRC-32 engines that work on their own, one for each direction. On the transmit side, flits stream through a one-cycle register stage. One accumulator per virtual channel folds in the 32-bit payload of every flit of a packet except the tail. When the tail flit passes, its payload is replaced with the finished checksum.

On the receive side, a second bank of per-channel accumulators processes the incoming packet in the same way. When the tail arrives, the bank compares its own result with the checksum the tail carries. The outcome is held as a per-channel match flag. A mismatch also sets a sticky per-channel error bit, which software clears by writing a one to it. A build-time switch removes both engines. Flits then pass through unchanged, and the flags keep their reset values.

Top module: `pkt_crc_guard`

## Requirements
- R1: While reset is high and after its release, `tx_wr_o` is 0, every bit of `crc_ok_o` is 1 and every bit of `crc_err_o` is 0, until the first flit moves.
- R2: A flit is `FW = 2 + V + 32` bits wide. Bit FW-1 is the header flag, bit FW-2 is the tail flag, bits FW-3 down to 32 are the one-hot channel select, and bits 31:0 are the payload. `tx_wr_o` equals `tx_wr_i` one cycle later. A written flit without the tail flag leaves on `tx_flit_o` one cycle later, unchanged.
- R3: A written tail flit leaves one cycle later with its flags and channel bits kept. Its payload holds the CRC-32 over the payloads of the earlier flits of that packet on that channel. The CRC-32 uses polynomial 0x04C11DB7, seed 0xFFFFFFFF and a final inversion, and folds in each 32-bit payload most-significant bit first.
- R4: A header flit restarts its channel's accumulator, and the header's own payload is included in the checksum. A single flit with both flags set carries 0x00000000.
- R5: Each channel keeps its own accumulator, so packets on different channels may interleave flit by flit without changing each other's checksum.
- R6: On a written receive tail flit for channel v, `crc_ok_o[v]` is updated one cycle later. It becomes 1 when the tail payload equals the receive-side CRC-32 of that packet and 0 otherwise. The other channels' flags keep their values.
- R7: A receive mismatch on channel v sets `crc_err_o[v]` one cycle later. The bit stays set through later matching packets until it is cleared.
- R8: `err_clr_i[v]` high clears `crc_err_o[v]` one cycle later. If a mismatch on channel v arrives in the same cycle, the bit is set instead.
- R9: With `CRC_EN` = 0, every flit, tail included, leaves unchanged one cycle later, `crc_ok_o` stays all ones and `crc_err_o` stays all zeros.
- R10: Cycles with `tx_wr_i` or `rx_wr_i` low are ignored: they change no accumulator and produce no output write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_flit_i | input | FW | Outgoing flit from the packetizer |
| tx_wr_i | input | 1 | Outgoing flit valid |
| tx_flit_o | output | FW | Outgoing flit with checksum in the tail |
| tx_wr_o | output | 1 | Outgoing flit valid, delayed one cycle |
| rx_flit_i | input | FW | Incoming flit from the network |
| rx_wr_i | input | 1 | Incoming flit valid |
| err_clr_i | input | V | Write-one-to-clear for the sticky error bits |
| crc_ok_o | output | V | Per-channel result of the last tail compare |
| crc_err_o | output | V | Per-channel sticky mismatch bits |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This covers the forwarded or rewritten transmit flit, the match flag after a receive tail, and the error bit after a mismatch or a clear. The bench drives each flit on a falling edge. It compares at the next falling edge, after the single capturing edge, and only then drives the next flit. A sweep over all channels and packet lengths of one to six flits feeds each transmitted tail back into the receive side. Corrupted tails, interleaved channels, idle cycles with junk data and clear/set collisions are then added. A second instance built with the engines removed receives the same stimulus.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
  localparam int PAY_W = 32;
  localparam logic [PAY_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [PAY_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // Fold one 32-bit word into the running remainder, MSB first.
  function automatic logic [PAY_W-1:0] crc32_step(input logic [PAY_W-1:0] cur,
                                                  input logic [PAY_W-1:0] word);
    logic [PAY_W-1:0] r;
    logic fb;
    r = cur;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = r[PAY_W-1] ^ word[i];
      r  = {r[PAY_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/pkt_crc_lane.sv
module pkt_crc_lane
  import pkt_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             absorb,
  input  logic [PAY_W-1:0] data,
  output logic [PAY_W-1:0] crc_now
);
  logic [PAY_W-1:0] acc;
  logic [PAY_W-1:0] base;

  // A header restarts from the seed in the same cycle it arrives.
  assign base    = start ? CRC_SEED : acc;
  assign crc_now = ~base;

  always_ff @(posedge clk) begin
    if (rst)         acc <= CRC_SEED;
    else if (absorb) acc <= crc32_step(base, data);
    else if (start)  acc <= CRC_SEED;
  end
endmodule

// File: rtl/pkt_crc_bank.sv
module pkt_crc_bank
  import pkt_crc_pkg::*;
#(
  parameter int V  = 4,
  localparam int FW = 2 + V + PAY_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [FW-1:0]             flit,
  input  logic                      wr,
  output logic [V-1:0][PAY_W-1:0]   crc_all
);
  logic         hdr, tail;
  logic [V-1:0] vc;
  logic [PAY_W-1:0] pay;

  assign hdr  = flit[FW-1];
  assign tail = flit[FW-2];
  assign vc   = flit[FW-3 -: V];
  assign pay  = flit[PAY_W-1:0];

  for (genvar v = 0; v < V; v++) begin : g_lane
    pkt_crc_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .start   (wr & vc[v] & hdr),
      .absorb  (wr & vc[v] & ~tail),
      .data    (pay),
      .crc_now (crc_all[v])
    );
  end
endmodule

// File: rtl/pkt_crc_tx.sv
module pkt_crc_tx
  import pkt_crc_pkg::*;
#(
  parameter int V  = 4,
  localparam int FW = 2 + V + PAY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] flit_i,
  input  logic          wr_i,
  output logic [FW-1:0] flit_o,
  output logic          wr_o
);
  logic [V-1:0][PAY_W-1:0] crc_all;
  logic [PAY_W-1:0]        crc_sel;
  logic [V-1:0]            vc;

  assign vc = flit_i[FW-3 -: V];

  pkt_crc_bank #(.V(V)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .flit    (flit_i),
    .wr      (wr_i),
    .crc_all (crc_all)
  );

  always_comb begin
    crc_sel = '0;
    for (int v = 0; v < V; v++)
      if (vc[v]) crc_sel = crc_sel | crc_all[v];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flit_o <= '0;
      wr_o   <= 1'b0;
    end else begin
      wr_o   <= wr_i;
      flit_o <= (wr_i && flit_i[FW-2]) ? {flit_i[FW-1:PAY_W], crc_sel} : flit_i;
    end
  end
endmodule

// File: rtl/pkt_crc_rx.sv
module pkt_crc_rx
  import pkt_crc_pkg::*;
#(
  parameter int V  = 4,
  localparam int FW = 2 + V + PAY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] flit_i,
  input  logic          wr_i,
  input  logic [V-1:0]  clr_i,
  output logic [V-1:0]  ok_o,
  output logic [V-1:0]  err_o
);
  logic [V-1:0][PAY_W-1:0] crc_all;
  logic [V-1:0]            hit, same;

  pkt_crc_bank #(.V(V)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .flit    (flit_i),
    .wr      (wr_i),
    .crc_all (crc_all)
  );

  for (genvar v = 0; v < V; v++) begin : g_flag
    assign hit[v]  = wr_i & flit_i[FW-2] & flit_i[PAY_W + v];
    assign same[v] = (crc_all[v] == flit_i[PAY_W-1:0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        ok_o[v]  <= 1'b1;
        err_o[v] <= 1'b0;
      end else begin
        if (hit[v]) ok_o[v] <= same[v];
        err_o[v] <= (err_o[v] & ~clr_i[v]) | (hit[v] & ~same[v]);
      end
    end
  end
endmodule

// File: rtl/pkt_crc_guard.sv
module pkt_crc_guard
  import pkt_crc_pkg::*;
#(
  parameter int V      = 4,
  parameter bit CRC_EN = 1'b1,
  localparam int FW    = 2 + V + PAY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] tx_flit_i,
  input  logic          tx_wr_i,
  output logic [FW-1:0] tx_flit_o,
  output logic          tx_wr_o,
  input  logic [FW-1:0] rx_flit_i,
  input  logic          rx_wr_i,
  input  logic [V-1:0]  err_clr_i,
  output logic [V-1:0]  crc_ok_o,
  output logic [V-1:0]  crc_err_o
);
  if (CRC_EN) begin : g_on
    pkt_crc_tx #(.V(V)) u_tx (
      .clk    (clk),
      .rst    (rst),
      .flit_i (tx_flit_i),
      .wr_i   (tx_wr_i),
      .flit_o (tx_flit_o),
      .wr_o   (tx_wr_o)
    );
    pkt_crc_rx #(.V(V)) u_rx (
      .clk    (clk),
      .rst    (rst),
      .flit_i (rx_flit_i),
      .wr_i   (rx_wr_i),
      .clr_i  (err_clr_i),
      .ok_o   (crc_ok_o),
      .err_o  (crc_err_o)
    );
  end else begin : g_off
    logic unused_rx;
    assign unused_rx = ^{rx_flit_i, rx_wr_i, err_clr_i};
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_flit_o <= '0;
        tx_wr_o   <= 1'b0;
      end else begin
        tx_flit_o <= tx_flit_i;
        tx_wr_o   <= tx_wr_i;
      end
    end
    assign crc_ok_o  = '1;
    assign crc_err_o = '0;
  end
endmodule

// File: rtl/pkt_crc_guard_chk.sv
module pkt_crc_guard_chk #(
  parameter int V  = 4,
  localparam int FW = 2 + V + 32
) (
  input logic          clk,
  input logic          rst,
  input logic [FW-1:0] tx_flit_i,
  input logic          tx_wr_i,
  input logic [FW-1:0] tx_flit_o,
  input logic          tx_wr_o,
  input logic [FW-1:0] rx_flit_i,
  input logic          rx_wr_i,
  input logic [V-1:0]  err_clr_i,
  input logic [V-1:0]  crc_ok_o,
  input logic [V-1:0]  crc_err_o
);
  // R2
  tx_wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr_i |=> tx_wr_o);
  // R10
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_wr_i |=> !tx_wr_o);
  // R2
  tx_body_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_i && !tx_flit_i[FW-2]) |=> tx_flit_o == $past(tx_flit_i));
  // R3
  tx_tail_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_i && tx_flit_i[FW-2]) |=> tx_flit_o[FW-1:32] == $past(tx_flit_i[FW-1:32]));
  // R6
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_wr_i && rx_flit_i[FW-2]) |=> $stable(crc_ok_o));
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rx_wr_i && rx_flit_i[FW-2]) && err_clr_i == '0) |=> $stable(crc_err_o));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr_i == '0) |=> ((~crc_err_o & $past(crc_err_o)) == '0));
endmodule

bind pkt_crc_guard pkt_crc_guard_chk #(.V(V)) u_chk (.*);

// File: tb/pkt_crc_guard_bench.sv
module pkt_crc_guard_bench;
  localparam int V  = 4;
  localparam int FW = 2 + V + 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [FW-1:0] tx_flit_i, rx_flit_i;
  logic          tx_wr_i, rx_wr_i;
  logic [V-1:0]  err_clr_i;
  logic [FW-1:0] tx_flit_o, off_flit_o;
  logic          tx_wr_o, off_wr_o;
  logic [V-1:0]  crc_ok_o, crc_err_o, off_ok_o, off_err_o;

  pkt_crc_guard #(.V(V), .CRC_EN(1'b1)) u_pkt_crc_guard (
    .clk(clk), .rst(rst), .tx_flit_i(tx_flit_i), .tx_wr_i(tx_wr_i),
    .tx_flit_o(tx_flit_o), .tx_wr_o(tx_wr_o), .rx_flit_i(rx_flit_i),
    .rx_wr_i(rx_wr_i), .err_clr_i(err_clr_i), .crc_ok_o(crc_ok_o),
    .crc_err_o(crc_err_o));

  pkt_crc_guard #(.V(V), .CRC_EN(1'b0)) u_pkt_crc_guard_off (
    .clk(clk), .rst(rst), .tx_flit_i(tx_flit_i), .tx_wr_i(tx_wr_i),
    .tx_flit_o(off_flit_o), .tx_wr_o(off_wr_o), .rx_flit_i(rx_flit_i),
    .rx_wr_i(rx_wr_i), .err_clr_i(err_clr_i), .crc_ok_o(off_ok_o),
    .crc_err_o(off_err_o));

  int checks = 0;
  int fails  = 0;
  logic [31:0]  tref [V];
  logic [31:0]  rref [V];
  logic [V-1:0] exp_ok, exp_err;
  logic [31:0]  last_tail;

  // Bytewise, bit-serial reference (MSB of each word first).
  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] d);
    logic [7:0] by;
    for (int b = 3; b >= 0; b--) begin
      by = d[8*b +: 8];
      for (int k = 7; k >= 0; k--) begin
        if (c[31] ^ by[k]) c = (c << 1) ^ 32'h04C11DB7;
        else               c = c << 1;
      end
    end
    return c;
  endfunction

  function automatic logic [FW-1:0] mkflit(input bit h, input bit t, input int vc,
                                           input logic [31:0] pay);
    logic [V-1:0] oh;
    oh = '0;
    oh[vc] = 1'b1;
    return {h, t, oh, pay};
  endfunction

  function automatic logic [31:0] gen(input int vc, input int len, input int i);
    return (32'h9E3779B9 * (vc * 64 + len * 8 + i + 1)) ^ 32'h5A5AA5A5;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tx_cycle(input bit h, input bit t, input int vc, input logic [31:0] pay,
                          input string req);
    logic [FW-1:0] f, e;
    f = mkflit(h, t, vc, pay);
    if (h) tref[vc] = 32'hFFFFFFFF;
    if (t) e = {f[FW-1:32], ~tref[vc]};
    else begin
      e = f;
      tref[vc] = ref_step(tref[vc], pay);
    end
    tx_flit_i = f;
    tx_wr_i   = 1'b1;
    @(negedge clk);
    check(req, 64'(tx_wr_o), 64'd1);
    check(req, 64'(tx_flit_o), 64'(e));
    check("R9", 64'(off_flit_o), 64'(f));
    if (t) last_tail = tx_flit_o[31:0];
    tx_wr_i = 1'b0;
  endtask

  task automatic tx_idle(input logic [FW-1:0] junk);
    tx_flit_i = junk;
    tx_wr_i   = 1'b0;
    @(negedge clk);
    check("R10", 64'(tx_wr_o), 64'd0);
  endtask

  task automatic rx_cycle(input bit w, input bit h, input bit t, input int vc,
                          input logic [31:0] pay, input logic [V-1:0] clr, input string req);
    logic [V-1:0] oh;
    bit           mism;
    oh = '0;
    oh[vc] = 1'b1;
    mism = 1'b0;
    if (w) begin
      if (h) rref[vc] = 32'hFFFFFFFF;
      if (t) begin
        exp_ok[vc] = (~rref[vc] == pay);
        mism = (~rref[vc] != pay);
      end else rref[vc] = ref_step(rref[vc], pay);
    end
    exp_err = (exp_err & ~clr) | (mism ? oh : '0);
    rx_flit_i = mkflit(h, t, vc, pay);
    rx_wr_i   = w;
    err_clr_i = clr;
    @(negedge clk);
    check(req, 64'(crc_ok_o), 64'(exp_ok));
    check(req, 64'(crc_err_o), 64'(exp_err));
    check("R9", 64'({off_ok_o, off_err_o}), 64'({{V{1'b1}}, {V{1'b0}}}));
    rx_wr_i   = 1'b0;
    err_clr_i = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; tx_wr_i = 1'b0; rx_wr_i = 1'b0; err_clr_i = '0;
    tx_flit_i = '0; rx_flit_i = '0;
    exp_ok = '1; exp_err = '0;
    for (int v = 0; v < V; v++) begin
      tref[v] = 32'hFFFFFFFF;
      rref[v] = 32'hFFFFFFFF;
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", 64'(tx_wr_o), 64'd0);
    check("R1", 64'(crc_ok_o), 64'(exp_ok));
    check("R1", 64'(crc_err_o), 64'(exp_err));
    rst = 1'b0;
    @(negedge clk);
    check("R1", 64'({tx_wr_o, crc_ok_o, crc_err_o}), 64'({1'b0, {V{1'b1}}, {V{1'b0}}}));

    // R3 R4 R6: sweep channels and lengths, loop each tail back to receive
    for (int vc = 0; vc < V; vc++) begin
      for (int len = 1; len <= 6; len++) begin
        for (int i = 0; i < len; i++)
          tx_cycle(i == 0, i == len - 1, vc, gen(vc, len, i), (len == 1) ? "R4" : "R3");
        for (int i = 0; i < len; i++)
          rx_cycle(1'b1, i == 0, i == len - 1, vc,
                   (i == len - 1) ? last_tail : gen(vc, len, i), '0, "R6");
      end
    end

    // R5 R10: interleave two channels with an idle junk cycle
    tx_cycle(1, 0, 0, 32'h11112222, "R5");
    tx_cycle(1, 0, 3, 32'h33334444, "R5");
    tx_cycle(0, 0, 0, 32'h55556666, "R5");
    tx_idle({2'b11, 4'b1001, 32'hDEADBEEF});
    tx_cycle(0, 0, 3, 32'h77778888, "R5");
    tx_cycle(0, 1, 0, 32'h0, "R5");
    tx_cycle(0, 1, 3, 32'h0, "R5");

    // R10 on receive: junk with rx_wr_i low between interleaved flits
    rx_cycle(1, 1, 0, 1, 32'hAAAA0001, '0, "R5");
    rx_cycle(1, 1, 0, 2, 32'hBBBB0002, '0, "R5");
    rx_cycle(0, 1, 1, 1, 32'h12345678, '0, "R10");
    rx_cycle(1, 0, 0, 1, 32'hAAAA0003, '0, "R5");
    rx_cycle(1, 0, 1, 2, ~ref_step(rref[2], 32'h0) ^ 32'h0, '0, "R5");
    rx_cycle(1, 0, 1, 1, ~rref[1], '0, "R5");

    // R6 R7: corrupted tail on channel 2, then a good packet
    rx_cycle(1, 1, 0, 2, 32'hC0FFEE00, '0, "R6");
    rx_cycle(1, 0, 1, 2, ~rref[2] ^ 32'h00000100, '0, "R7");
    rx_cycle(1, 1, 0, 2, 32'hC0FFEE01, '0, "R6");
    rx_cycle(1, 0, 1, 2, ~rref[2], '0, "R7");

    // R8: clear on an idle cycle
    rx_cycle(0, 0, 0, 0, 32'h0, 4'b0100, "R8");
    // R8: mismatch and clear in the same cycle on channel 1
    rx_cycle(1, 1, 0, 1, 32'h00000001, '0, "R8");
    rx_cycle(1, 0, 1, 1, ~rref[1] ^ 32'h80000000, 4'b0010, "R8");
    // R8: matching tail with clear on channel 1
    rx_cycle(1, 1, 1, 1, 32'h00000000, 4'b0010, "R8");
    // R7: single-flit mismatch on channel 0, stays set
    rx_cycle(1, 1, 1, 0, 32'h00000001, '0, "R7");
    rx_cycle(0, 0, 0, 0, 32'h0, '0, "R7");

    summary();
    $finish;
  end
endmodule